// File: doc/BRIEF.md
# Group-Skip Binary Adder

This block adds two unsigned operands of `WIDTH` bits and a carry-in, and returns a `WIDTH`-bit sum and a carry-out. It has no clock and no state: the result depends only on the present inputs. The arithmetic result is identical to that of a plain bit-serial carry chain.

The operand bits are split into equal segments of `GROUP` bits, starting at the least significant bit. Each bit produces three mutually exclusive signals from its two operand bits alone: generate, propagate and kill. Inside a segment the carry passes from bit to bit. A segment in which every bit propagates forwards its incoming carry straight to the next segment through a multiplexer, so a long carry does not have to walk through every bit. The carry-in feeds the lowest segment, and the carry leaving the highest segment is the adder's carry-out.

Use it wherever a wide combinational adder is needed and a shorter worst-case carry path than a pure ripple chain is wanted, at the cost of one multiplexer per segment.

Top module: `carry_bypass_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals add_a + add_b + cin, taken as unsigned numbers.
- R2: Each bit is in exactly one class: generate (both operand bits 1), kill (both 0) or propagate (bits differ). With both operands all ones, cout is 1 whatever cin is; with both operands zero, cout is 0.
- R3: When every bit propagates (add_a XOR add_b all ones), every sum bit equals the inverse of cin and cout equals cin.
- R4: When all bits of a segment propagate, the carry leaving that segment equals the carry entering it, and the rippled carry of that segment agrees with it.
- R5: cin enters at bit 0: with both operands zero, sum equals cin in bit 0 and zero elsewhere.
- R6: A carry generated at bit 0 runs through propagating bits up to a most significant bit that kills it: add_a = 1 with add_b having all bits set except the MSB gives sum with only the MSB set and cout 0.
- R7: WIDTH must be a whole multiple of GROUP, with GROUP at least 1; any other combination stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| add_a | input | WIDTH | First operand, unsigned |
| add_b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Every result of this block is due in the same cycle as its stimulus: no register lies between any input and either output. The bench therefore changes the operands, waits a fixed few nanoseconds with no clock edge involved, and samples sum and cout before the next change. A small eight-bit, two-bit-segment copy is swept over every operand pair with both carry-in values. The default sixteen-bit, four-bit-segment copy gets directed vectors for the all-propagate, generate, kill and MSB-kill corners, plus random operands.

// File: rtl/cba_pkg.sv
// Shared helpers for the group-skip adder.
// Assumes: callers have already checked that width divides evenly by group.
package cba_pkg;

    // Number of carry segments in an adder of the given width.
    function automatic int unsigned cba_segments(input int unsigned width,
                                                 input int unsigned group);
        return (group == 0) ? 1 : width / group;
    endfunction

    // Per-bit carry classification, exactly one field is set.
    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } cba_class_t;

endpackage

// File: rtl/cba_bit_cell.sv
// One-bit full adder cell with explicit carry classification.
// Assumes: the classification uses only the operand bits, never the carry.
module cba_bit_cell
    import cba_pkg::*;
(
    input  logic       op_a,
    input  logic       op_b,
    input  logic       c_in,
    output cba_class_t cls,
    output logic       c_out,
    output logic       s_out
);

    // Classify the bit from its operands alone.
    always_comb begin
        cls.gen  = op_a & op_b;
        cls.prop = op_a ^ op_b;
        cls.kill = ~op_a & ~op_b;
    end

    // Carry and sum from the class and the incoming carry.
    always_comb begin
        c_out = cls.gen | (cls.prop & c_in);
        s_out = cls.prop ^ c_in;
    end

endmodule

// File: rtl/cba_segment.sv
// A segment of GROUP bits: internal ripple chain plus a skip multiplexer.
// Assumes: GROUP >= 1. seg_cout takes seg_cin directly when all bits propagate.
module cba_segment
    import cba_pkg::*;
#(
    parameter int unsigned GROUP = 4
) (
    input  logic [GROUP-1:0] seg_a,
    input  logic [GROUP-1:0] seg_b,
    input  logic             seg_cin,
    output logic [GROUP-1:0] seg_sum,
    output logic [GROUP-1:0] seg_gen,
    output logic [GROUP-1:0] seg_prop,
    output logic [GROUP-1:0] seg_kill,
    output logic             seg_skip,
    output logic             seg_ripple,
    output logic             seg_cout
);

    logic [GROUP:0] chain;

    assign chain[0] = seg_cin;

    genvar k;
    generate
        for (k = 0; k < GROUP; k++) begin : g_bit
            cba_class_t cls_k;
            cba_bit_cell u_cell (
                .op_a  (seg_a[k]),
                .op_b  (seg_b[k]),
                .c_in  (chain[k]),
                .cls   (cls_k),
                .c_out (chain[k+1]),
                .s_out (seg_sum[k])
            );
            assign seg_gen[k]  = cls_k.gen;
            assign seg_prop[k] = cls_k.prop;
            assign seg_kill[k] = cls_k.kill;
        end
    endgenerate

    // Skip condition: every bit of the segment propagates.
    always_comb seg_skip = &seg_prop;

    // Segment carry-out: forwarded carry when skipping, rippled carry otherwise.
    always_comb begin
        seg_ripple = chain[GROUP];
        seg_cout   = seg_skip ? seg_cin : chain[GROUP];
    end

endmodule

// File: rtl/carry_bypass_adder.sv
// Combinational unsigned adder built from GROUP-bit segments with carry skip.
// Assumes: WIDTH is a multiple of GROUP (checked at elaboration). No clock, no state.
module carry_bypass_adder
    import cba_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GROUP = 4
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int unsigned NSEG = cba_segments(WIDTH, GROUP);

    // R7: reject a width that does not split into whole segments.
    generate
        if (GROUP < 1 || (WIDTH % GROUP) != 0) begin : g_bad_cfg
            $error("carry_bypass_adder: WIDTH %0d is not a multiple of GROUP %0d",
                   WIDTH, GROUP);
        end
    endgenerate

    logic [NSEG:0]    seg_carry;
    logic [NSEG-1:0]  seg_skip;
    logic [NSEG-1:0]  seg_ripple;
    logic [WIDTH-1:0] bit_gen;
    logic [WIDTH-1:0] bit_prop;
    logic [WIDTH-1:0] bit_kill;

    assign seg_carry[0] = cin;

    genvar s;
    generate
        for (s = 0; s < NSEG; s++) begin : g_seg
            cba_segment #(.GROUP(GROUP)) u_seg (
                .seg_a      (add_a[s*GROUP +: GROUP]),
                .seg_b      (add_b[s*GROUP +: GROUP]),
                .seg_cin    (seg_carry[s]),
                .seg_sum    (sum[s*GROUP +: GROUP]),
                .seg_gen    (bit_gen[s*GROUP +: GROUP]),
                .seg_prop   (bit_prop[s*GROUP +: GROUP]),
                .seg_kill   (bit_kill[s*GROUP +: GROUP]),
                .seg_skip   (seg_skip[s]),
                .seg_ripple (seg_ripple[s]),
                .seg_cout   (seg_carry[s+1])
            );
        end
    endgenerate

    // The last segment's carry leaves the adder.
    always_comb cout = seg_carry[NSEG];

endmodule

// File: rtl/cba_checker.sv
// Assertion checker for the group-skip adder, attached by bind.
// Assumes: purely combinational target, so checks are immediate on settled values.
module cba_checker #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GROUP = 4,
    parameter int unsigned NSEG  = 4
) (
    input logic [WIDTH-1:0] add_a,
    input logic [WIDTH-1:0] add_b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH-1:0] bit_gen,
    input logic [WIDTH-1:0] bit_prop,
    input logic [WIDTH-1:0] bit_kill,
    input logic [NSEG:0]    seg_carry,
    input logic [NSEG-1:0]  seg_skip,
    input logic [NSEG-1:0]  seg_ripple
);

    logic [WIDTH:0] ref_total;
    logic           inputs_known;

    // Reference total and a guard against unknown inputs.
    always_comb begin
        ref_total    = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, cin};
        inputs_known = !$isunknown({add_a, add_b, cin});
    end

    // Arithmetic and corner-case checks on settled values.
    always_comb begin
        if (inputs_known) begin
            AST_SUM_EXACT: assert ({cout, sum} == ref_total) else $error("sum mismatch"); // R1
            for (int i = 0; i < int'(WIDTH); i++) begin
                AST_BIT_CLASS: assert ($onehot({bit_gen[i], bit_prop[i], bit_kill[i]})) else $error("bit class"); // R2
            end
            if ((add_a ^ add_b) == {WIDTH{1'b1}}) begin
                AST_ALL_PROP_PASS: assert (sum == {WIDTH{~cin}} && cout == cin) else $error("all-propagate"); // R3
            end
            for (int s = 0; s < int'(NSEG); s++) begin
                if (seg_skip[s]) begin
                    AST_SKIP_AGREES: assert (seg_ripple[s] == seg_carry[s] && seg_carry[s+1] == seg_carry[s]) else $error("skip path"); // R4
                end
            end
            if (add_a == '0 && add_b == '0) begin
                AST_ZERO_ADD: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout) else $error("zero add"); // R5
            end
        end
    end

endmodule

bind carry_bypass_adder cba_checker #(
    .WIDTH (WIDTH),
    .GROUP (GROUP),
    .NSEG  (NSEG)
) u_cba_checker (
    .add_a      (add_a),
    .add_b      (add_b),
    .cin        (cin),
    .sum        (sum),
    .cout       (cout),
    .bit_gen    (bit_gen),
    .bit_prop   (bit_prop),
    .bit_kill   (bit_kill),
    .seg_carry  (seg_carry),
    .seg_skip   (seg_skip),
    .seg_ripple (seg_ripple)
);

// File: tb/test_carry_bypass_adder.sv
// Bench: exhaustive sweep of an 8-bit/2-bit-segment copy, directed and random
// vectors on the default 16-bit/4-bit-segment copy.
module test_carry_bypass_adder;

    localparam int W  = 16;
    localparam int WS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [W-1:0]  a16, b16, s16;
    logic          c16, co16;
    logic [WS-1:0] a8, b8, s8;
    logic          c8, co8;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    carry_bypass_adder #(.WIDTH(W), .GROUP(4)) i_carry_bypass_adder (
        .add_a (a16), .add_b (b16), .cin (c16), .sum (s16), .cout (co16)
    );

    carry_bypass_adder #(.WIDTH(WS), .GROUP(2)) i_carry_bypass_adder_small (
        .add_a (a8), .add_b (b8), .cin (c8), .sum (s8), .cout (co8)
    );

    // Compare one 17-bit result of the wide copy.
    task automatic chk16(input string tag, input logic [W:0] exp);
        checks++;
        if ({co16, s16} !== exp) begin
            failures++;
            $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h",
                     tag, a16, b16, c16, {co16, s16}, exp);
        end
    endtask

    // Drive the wide copy and check after settling.
    task automatic run16(input string tag, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c,
                         input logic [W:0] exp);
        a16 = a; b16 = b; c16 = c;
        #3;
        chk16(tag, exp);
        #1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Idle state: zero inputs give zero outputs (R1, R5).
        chk16("R1 idle", '0);

        // R5: carry-in enters at bit 0.
        run16("R5 cin only", '0, '0, 1'b1, 17'h00001);
        // R2: generate in every bit, both carry-in values.
        run16("R2 all gen cin0", 16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE);
        run16("R2 all gen cin1", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
        // R2: kill in every bit.
        run16("R2 all kill", '0, '0, 1'b0, 17'h00000);
        // R3: every bit propagates.
        run16("R3 all prop cin1", 16'hA5C3, 16'h5A3C, 1'b1, 17'h10000);
        run16("R3 all prop cin0", 16'h00FF, 16'hFF00, 1'b0, 17'h0FFFF);
        // R6: carry from bit 0 killed at the MSB.
        run16("R6 msb kill", 16'h0001, 16'h7FFF, 1'b0, 17'h08000);
        // R4: middle segments skip, carry made in segment 0 reaches the top.
        run16("R4 skip middle", 16'h0F0F, 16'h00F1, 1'b0, 17'h01000);
        run16("R4 skip to cout", 16'hFFF8, 16'h0008, 1'b0, 17'h10000);

        // R1: random operands on the wide copy.
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] ra, rb;
            logic         rc;
            ra = W'($urandom);
            rb = W'($urandom);
            rc = 1'($urandom);
            run16("R1 random", ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc});
        end

        // R1, R4: exhaustive sweep of the small copy.
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    logic [WS:0] exp8;
                    a8 = WS'(ia); b8 = WS'(ib); c8 = 1'(ic);
                    exp8 = (WS+1)'(ia + ib + ic);
                    #1;
                    checks++;
                    if ({co8, s8} !== exp8) begin
                        failures++;
                        $display("FAIL R1 sweep: a=%h b=%h cin=%0d actual=%h expected=%h",
                                 a8, b8, c8, {co8, s8}, exp8);
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule